// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the addressing layer of a slave on a single-wire, open-drain, multidrop bus. A bit-level front end turns the analog line activity into three kinds of events. These are a bus reset, a bit written by the master, and a request for the slave to supply a bit. After every bus reset the block collects one 8-bit command. It then runs the addressing dialogue that the command selects: it sends its 64-bit identity, compares the identity against the master's bits, or takes part in the bit-wise binary search over all slaves on the bus. When the slave has been selected, the block raises an enable for the function layer above it.

The block keeps two flags across bus resets. The first is a resume-context flag that remembers this slave was the last one addressed individually, so the master can select it again without sending the full address. The second is a fast-speed flag that two of the commands set and that the front end uses to choose its timing. A long bus reset returns the bus to normal speed; a short one keeps the current speed. The identity is a parameter. Its default holds the family code 3Ah in the low byte, a 48-bit serial number in the middle and a check byte in the top byte.

Top module: `owrl_rom_layer`

## Requirements
- R1: After rst_n is released, func_enable and overdrive are 0 and bit_tx is 1. Bit strobes that arrive before the first reset_seen pulse are ignored.
- R2: A reset_seen pulse puts the block in the command-wait state from any state, and func_enable is 0 from the next cycle. If reset_long is 1 in the same cycle, overdrive becomes 0; otherwise overdrive keeps its value.
- R3: The command byte is taken from the next 8 bit_rx_valid strobes, least significant bit first. The codes are 33h read identity, 55h match, F0h search, CCh skip, A5h resume, 3Ch fast skip and 69h fast match.
- R4: After 33h, the next 64 bit_tx_req strobes return identity bits 0 through 63 on bit_tx, in that order. After the 64th strobe, func_enable is 1.
- R5: After 55h, each of the next 64 written bits is compared with identity bits 0 through 63. If all 64 match, func_enable becomes 1. At the first mismatch the block stops responding: func_enable stays 0 and later strobes have no effect until reset_seen.
- R6: After F0h, each identity bit i is handled in three steps: the slave sends bit i, then sends its complement, then reads the master's bit. If the master's bit differs from bit i, the block drops out until reset_seen. After all 64 bits match, func_enable becomes 1.
- R7: After CCh, func_enable is 1 immediately.
- R8: The resume-context flag is set only when a 55h, F0h or 69h command completes successfully. Commands 33h, 55h, F0h, CCh, 3Ch and 69h clear it when their code is received. After A5h, func_enable becomes 1 only if the flag is set; otherwise the block waits for reset_seen.
- R9: 3Ch sets overdrive and then enables the function layer at once. 69h sets overdrive once its code is received and then performs the 64-bit compare described in R5.
- R10: Any other command code leaves func_enable at 0 until the next reset_seen.
- R11: bit_tx is 1 whenever the block is not in one of its sending steps (identity read or the first two search steps). This includes the states after a dropout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_seen | input | 1 | One-cycle pulse: the front end detected a bus reset |
| reset_long | input | 1 | Qualifies reset_seen: the reset was long enough to return the bus to normal speed |
| bit_rx_valid | input | 1 | One-cycle pulse: a master write slot finished, with its bit on bit_rx |
| bit_rx | input | 1 | Bit written by the master |
| bit_tx_req | input | 1 | One-cycle pulse: the front end is serving a read slot and samples bit_tx |
| bit_tx | output | 1 | Bit to send in the current read slot; 1 releases the line |
| func_enable | output | 1 | The function layer may take over the bus |
| overdrive | output | 1 | Fast bus speed selected |

## Verification
The bench runs each command with a correct identity and also with a single flipped bit at a random position. This distinguishes a slave that drops out at the exact mismatching bit from one that checks only at the end or ignores late bits. Search is run with the master agreeing on every bit and with the master disagreeing at a random bit, and the complement in each step is checked. Random command sequences over a running model of the two flags show whether resume depends on the correct history. Short resets, long resets and resets in the middle of a dialogue show whether the speed flag is kept or cleared correctly and whether a reset aborts a dialogue at any state.

// File: rtl/owrl_pkg.sv
// Package: shared state type, command codes and decode result for the
// single-wire ROM command layer. Assumes 8-bit command codes.
package owrl_pkg;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,  // idle until the next bus reset
        ST_CMD    = 3'd1,  // collecting the command byte
        ST_READ   = 3'd2,  // sending the identity
        ST_MATCH  = 3'd3,  // comparing master bits with the identity
        ST_SEARCH = 3'd4,  // bit-wise search dialogue
        ST_FUNC   = 3'd5   // selected, function layer owns the bus
    } rom_state_t;

    localparam logic [7:0] CODE_READ    = 8'h33;
    localparam logic [7:0] CODE_MATCH   = 8'h55;
    localparam logic [7:0] CODE_SEARCH  = 8'hF0;
    localparam logic [7:0] CODE_SKIP    = 8'hCC;
    localparam logic [7:0] CODE_RESUME  = 8'hA5;
    localparam logic [7:0] CODE_FSKIP   = 8'h3C;
    localparam logic [7:0] CODE_FMATCH  = 8'h69;

    typedef struct packed {
        rom_state_t next;     // state entered after the command byte
        logic       clr_ctx;  // clear the resume-context flag
        logic       set_od;   // select fast speed
    } cmd_action_t;

endpackage

// File: rtl/owrl_cmd_shift.sv
// Module: collects the command byte one bit at a time, least significant
// bit first. Assumes shift_en pulses once per received bit and that clear
// is held whenever no command byte is being collected.
module owrl_cmd_shift #(
    parameter int CMD_W = 8,
    localparam int CNT_W = $clog2(CMD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CMD_W-1:0] byte_next,
    output logic             last_bit
);

    logic [CMD_W-2:0] sr;
    logic [CNT_W-1:0] cnt;

    // The byte as it stands once the incoming bit is included.
    assign byte_next = {bit_in, sr};
    assign last_bit  = (cnt == CNT_W'(CMD_W - 1));

    // Shift register and bit counter for the byte under collection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sr  <= byte_next[CMD_W-1:1];
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/owrl_cmd_decode.sv
// Module: maps a complete command byte and the resume-context flag to
// the next state and the flag updates. Purely combinational.
module owrl_cmd_decode
    import owrl_pkg::*;
(
    input  logic [7:0]  code,
    input  logic        ctx,
    output cmd_action_t act
);

    // Decode the command byte into an action.
    always_comb begin
        act = '{next: ST_WAIT, clr_ctx: 1'b0, set_od: 1'b0};
        unique case (code)
            CODE_READ:   act = '{next: ST_READ,   clr_ctx: 1'b1, set_od: 1'b0};
            CODE_MATCH:  act = '{next: ST_MATCH,  clr_ctx: 1'b1, set_od: 1'b0};
            CODE_SEARCH: act = '{next: ST_SEARCH, clr_ctx: 1'b1, set_od: 1'b0};
            CODE_SKIP:   act = '{next: ST_FUNC,   clr_ctx: 1'b1, set_od: 1'b0};
            CODE_FSKIP:  act = '{next: ST_FUNC,   clr_ctx: 1'b1, set_od: 1'b1};
            CODE_FMATCH: act = '{next: ST_MATCH,  clr_ctx: 1'b1, set_od: 1'b1};
            CODE_RESUME: act = '{next: ctx ? ST_FUNC : ST_WAIT,
                                 clr_ctx: 1'b0, set_od: 1'b0};
            default:     act = '{next: ST_WAIT,   clr_ctx: 1'b0, set_od: 1'b0};
        endcase
    end

endmodule

// File: rtl/owrl_id_select.sv
// Module: picks one bit of the constant identity by index. Assumes the
// index stays below ID_W.
module owrl_id_select #(
    parameter int          ID_W   = 64,
    parameter logic [63:0] ROM_ID = 64'h5C00_0012_3456_783A,
    localparam int         IDX_W  = $clog2(ID_W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);

    localparam logic [ID_W-1:0] ID_VEC = ROM_ID[ID_W-1:0];

    // Bit selection from the constant identity.
    assign id_bit = ID_VEC[idx];

endmodule

// File: rtl/owrl_rom_layer.sv
// Module: addressing layer of a single-wire bus slave. After each bus
// reset it collects a command byte and runs the read, match, search,
// skip, resume or fast-speed dialogue, then enables the function layer.
// Assumes the front end gives exactly one strobe per time slot:
// bit_rx_valid for write slots and bit_tx_req for read slots, and that
// bit_tx is sampled combinationally while bit_tx_req is high.
module owrl_rom_layer #(
    parameter int          ID_W   = 64,
    parameter logic [63:0] ROM_ID = 64'h5C00_0012_3456_783A,
    parameter int          CMD_W  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_seen,
    input  logic reset_long,
    input  logic bit_rx_valid,
    input  logic bit_rx,
    input  logic bit_tx_req,
    output logic bit_tx,
    output logic func_enable,
    output logic overdrive
);
    import owrl_pkg::*;

    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

    rom_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [1:0]       phase;
    logic             resume_ctx;
    logic             od_q;
    logic             id_bit;
    logic [CMD_W-1:0] cmd_byte;
    logic             cmd_last;
    logic             cmd_shift;
    cmd_action_t      act;

    assign cmd_shift = (state == ST_CMD) && bit_rx_valid && !reset_seen;

    owrl_cmd_shift #(.CMD_W(CMD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (reset_seen || (state != ST_CMD)),
        .shift_en  (cmd_shift),
        .bit_in    (bit_rx),
        .byte_next (cmd_byte),
        .last_bit  (cmd_last)
    );

    owrl_cmd_decode u_decode (
        .code (cmd_byte[7:0]),
        .ctx  (resume_ctx),
        .act  (act)
    );

    owrl_id_select #(.ID_W(ID_W), .ROM_ID(ROM_ID)) u_id (
        .idx    (idx),
        .id_bit (id_bit)
    );

    // Main dialogue state machine with the two sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT;
            idx        <= '0;
            phase      <= 2'd0;
            resume_ctx <= 1'b0;
            od_q       <= 1'b0;
        end else if (reset_seen) begin
            state <= ST_CMD;
            idx   <= '0;
            phase <= 2'd0;
            if (reset_long) od_q <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: if (bit_rx_valid && cmd_last) begin
                    state <= act.next;
                    idx   <= '0;
                    phase <= 2'd0;
                    if (act.clr_ctx) resume_ctx <= 1'b0;
                    if (act.set_od)  od_q       <= 1'b1;
                end
                ST_READ: if (bit_tx_req) begin
                    if (idx == IDX_LAST) state <= ST_FUNC;
                    else                 idx   <= idx + 1'b1;
                end
                ST_MATCH: if (bit_rx_valid) begin
                    if (bit_rx != id_bit) begin
                        state <= ST_WAIT;
                    end else if (idx == IDX_LAST) begin
                        state      <= ST_FUNC;
                        resume_ctx <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (phase != 2'd2) begin
                        if (bit_tx_req) phase <= phase + 1'b1;
                    end else if (bit_rx_valid) begin
                        phase <= 2'd0;
                        if (bit_rx != id_bit) begin
                            state <= ST_WAIT;
                        end else if (idx == IDX_LAST) begin
                            state      <= ST_FUNC;
                            resume_ctx <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Bit offered to the front end for the current read slot.
    always_comb begin
        bit_tx = 1'b1;
        if (state == ST_READ) begin
            bit_tx = id_bit;
        end else if (state == ST_SEARCH) begin
            if (phase == 2'd0)      bit_tx = id_bit;
            else if (phase == 2'd1) bit_tx = ~id_bit;
        end
    end

    assign func_enable = (state == ST_FUNC);
    assign overdrive   = od_q;

    // R2: a bus reset withdraws the function layer's enable.
    a_r2_reset_drops_func: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !func_enable);

    // R2: a long reset returns to normal speed.
    a_r2_long_reset_clears_od: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_seen && reset_long) |=> !overdrive);

    // R2: a short reset keeps the speed.
    a_r2_short_reset_keeps_od: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_seen && !reset_long) |=> (overdrive == $past(overdrive)));

    // R8: the resume context is only gained by completing an address dialogue.
    a_r8_ctx_from_dialogue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_ctx) |-> ($past(state) inside {ST_MATCH, ST_SEARCH}));

    // R5: the function layer is entered only from a command or a finished dialogue.
    a_r5_func_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(func_enable) |-> ($past(state) inside {ST_CMD, ST_READ, ST_MATCH, ST_SEARCH}));

    // R11: the line is released outside the sending steps.
    a_r11_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_WAIT, ST_CMD, ST_MATCH, ST_FUNC}) |-> bit_tx);

    // R6: the search step counter stays within its three steps.
    a_r6_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |-> (phase != 2'd3));

endmodule

// File: tb/tb_owrl_rom_layer.sv
module tb_owrl_rom_layer;

    localparam logic [63:0] TB_ID = 64'h5C00_0012_3456_783A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_seen = 1'b0, reset_long = 1'b0;
    logic bit_rx_valid = 1'b0, bit_rx = 1'b0, bit_tx_req = 1'b0;
    logic bit_tx, func_enable, overdrive;

    int n_chk = 0, n_fail = 0;
    logic exp_ctx = 1'b0, exp_od = 1'b0;

    always #2 clk = ~clk;

    owrl_rom_layer #(.ID_W(64), .ROM_ID(TB_ID), .CMD_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .reset_seen(reset_seen), .reset_long(reset_long),
        .bit_rx_valid(bit_rx_valid), .bit_rx(bit_rx), .bit_tx_req(bit_tx_req),
        .bit_tx(bit_tx), .func_enable(func_enable), .overdrive(overdrive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic lng);
        @(negedge clk); reset_seen = 1'b1; reset_long = lng;
        @(negedge clk); reset_seen = 1'b0; reset_long = 1'b0;
        if (lng) exp_od = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk); bit_rx_valid = 1'b1; bit_rx = b;
        @(negedge clk); bit_rx_valid = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        @(negedge clk); bit_tx_req = 1'b1; #1 b = bit_tx;
        @(negedge clk); bit_tx_req = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);
    endtask

    // Expected ctx/od effect of a recognised code when its byte lands.
    function automatic bit is_known(input logic [7:0] c);
        return c inside {8'h33, 8'h55, 8'hF0, 8'hCC, 8'hA5, 8'h3C, 8'h69};
    endfunction

    // Send the identity with bit bad flipped (bad < 0: none).
    task automatic send_id(input int bad);
        for (int i = 0; i < 64; i++) wr_bit((i == bad) ? ~TB_ID[i] : TB_ID[i]);
    endtask

    task automatic run_match(input logic [7:0] code, input int bad, input string req);
        wr_byte(code);
        exp_ctx = 1'b0;
        if (code == 8'h69) exp_od = 1'b1;
        chk(overdrive == exp_od, "R9", "speed after match code", overdrive, exp_od);
        send_id(bad);
        if (bad < 0) exp_ctx = 1'b1;
        chk(func_enable == (bad < 0), req, "enable after address compare", func_enable, bad < 0);
        chk(bit_tx == 1'b1, "R11", "line released after compare", bit_tx, 1);
    endtask

    task automatic run_search(input int bad);
        logic a, b;
        bit ok = 1'b1;
        wr_byte(8'hF0);
        exp_ctx = 1'b0;
        for (int i = 0; i < 64; i++) begin
            rd_bit(a); rd_bit(b);
            if (a !== TB_ID[i] || b !== ~TB_ID[i]) ok = 1'b0;
            wr_bit((i == bad) ? ~TB_ID[i] : TB_ID[i]);
            if (i == bad) break;
        end
        chk(ok, "R6", "search bit and complement", ok, 1);
        if (bad < 0) exp_ctx = 1'b1;
        chk(func_enable == (bad < 0), "R6", "enable after search", func_enable, bad < 0);
        if (bad >= 0) begin
            rd_bit(a);
            chk(a == 1'b1, "R11", "line released after search dropout", a, 1);
        end
    endtask

    task automatic run_resume();
        wr_byte(8'hA5);
        chk(func_enable == exp_ctx, "R8", "resume enable", func_enable, exp_ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic b;
        bit ok;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(func_enable == 0, "R1", "enable after rst_n", func_enable, 0);
        chk(overdrive == 0, "R1", "speed after rst_n", overdrive, 0);
        chk(bit_tx == 1, "R1", "line after rst_n", bit_tx, 1);
        wr_byte(8'hCC);
        chk(func_enable == 0, "R1", "strobes before first bus reset ignored", func_enable, 0);

        // R4: read identity
        do_reset(1'b1);
        wr_byte(8'h33);
        exp_ctx = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            rd_bit(b);
            if (b !== TB_ID[i]) ok = 1'b0;
        end
        chk(ok, "R4", "identity bits in order", ok, 1);
        chk(func_enable == 1, "R4", "enable after read", func_enable, 1);

        // R8: resume without context
        do_reset(1'b0);
        run_resume();
        // R5 then R8: match and resume
        do_reset(1'b0); run_match(8'h55, -1, "R5");
        do_reset(1'b0); run_resume();
        // R7 and R3 (skip code CCh sent LSB first); skip clears context
        do_reset(1'b0); wr_byte(8'hCC); exp_ctx = 1'b0;
        chk(func_enable == 1, "R7", "skip enables (R3 bit order)", func_enable, 1);
        do_reset(1'b0); run_resume();
        // R5: mismatch at first and last bit
        do_reset(1'b0); run_match(8'h55, 0, "R5");
        do_reset(1'b0); run_match(8'h55, 63, "R5");
        // R6: full search and dropout
        do_reset(1'b0); run_search(-1);
        do_reset(1'b0); run_resume();
        do_reset(1'b0); run_search(int'($urandom_range(0, 63)));
        // R9: fast skip, short reset keeps speed, fast match, long reset
        do_reset(1'b0); wr_byte(8'h3C); exp_od = 1'b1; exp_ctx = 1'b0;
        chk(overdrive == 1 && func_enable == 1, "R9", "fast skip", {overdrive, func_enable}, 2'b11);
        do_reset(1'b0);
        chk(overdrive == 1, "R2", "short reset keeps speed", overdrive, 1);
        run_match(8'h69, -1, "R9");
        do_reset(1'b1);
        chk(overdrive == 0, "R2", "long reset clears speed", overdrive, 0);
        // R10: unknown code
        wr_byte(8'h00);
        chk(func_enable == 0, "R10", "unknown code 00h", func_enable, 0);
        wr_byte(8'hCC);
        chk(func_enable == 0, "R10", "later strobes ignored after unknown code", func_enable, 0);
        // R2: reset in the middle of a read
        do_reset(1'b0); wr_byte(8'h33); exp_ctx = 1'b0;
        for (int i = 0; i < 10; i++) rd_bit(b);
        do_reset(1'b0);
        chk(func_enable == 0 && bit_tx == 1, "R2", "reset aborts read", {func_enable, bit_tx}, 2'b01);
        wr_byte(8'hCC);
        chk(func_enable == 1, "R2", "command accepted after abort", func_enable, 1);

        // Random command mix against the flag model
        for (int n = 0; n < 40; n++) begin
            int k;
            logic [7:0] c;
            do_reset(logic'($urandom_range(0, 1)));
            k = int'($urandom_range(0, 9));
            case (k)
                0: begin
                    wr_byte(8'h33); exp_ctx = 1'b0;
                    for (int i = 0; i < 64; i++) rd_bit(b);
                    chk(func_enable == 1, "R4", "random read", func_enable, 1);
                end
                1: run_match(8'h55, -1, "R5");
                2: run_match(8'h55, int'($urandom_range(0, 63)), "R5");
                3: run_search(-1);
                4: run_search(int'($urandom_range(0, 63)));
                5: begin
                    wr_byte(8'hCC); exp_ctx = 1'b0;
                    chk(func_enable == 1, "R7", "random skip", func_enable, 1);
                end
                6: run_resume();
                7: begin
                    do c = 8'($urandom_range(0, 255)); while (is_known(c));
                    wr_byte(c);
                    chk(func_enable == 0, "R10", "random unknown code", func_enable, 0);
                end
                8: begin
                    wr_byte(8'h3C); exp_ctx = 1'b0; exp_od = 1'b1;
                    chk(func_enable == 1, "R9", "random fast skip", func_enable, 1);
                end
                default: run_match(8'h69, -1, "R9");
            endcase
            chk(overdrive == exp_od, "R2", "speed flag model", overdrive, exp_od);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule